// File: doc/BRIEF.md
# Semaphore-Gated Descriptor Sequencer

This block is one channel of a descriptor-driven DMA engine. Software writes the byte address of a first command into a pointer register, then writes a count into a semaphore register. While the count is non-zero and the channel's gate bit is clear, the sequencer reads two-word command descriptors from memory. It spends each command's stated number of execute cycles, then follows the chain link to the next descriptor. A command that has its decrement flag set lowers the count by one when it completes. The channel stops when the count reaches zero or when a command without the chain flag completes.

A descriptor occupies two 32-bit words. The word at the descriptor's address holds the byte address of the next descriptor. The word at address + 4 holds the flags: bit 0 chains to the next descriptor, bit 1 decrements the semaphore, and bit 2 raises the completion interrupt. Bits 31:16 of that word hold the execute-cycle count. Software can add to the semaphore at any time to lengthen a running chain. A gate bit stops the channel at once. A self-clearing reset bit empties the channel. A completion status bit, combined with an enable bit, drives the interrupt line.

Top module: `dma_sem_seq`

## Requirements
- R1: In register map word 0 (pointer), word 1 (semaphore), word 2 (control read), word 3 (control set) and word 4 (control clear), a semaphore write of a non-zero value with the gate clear starts fetching at the pointer address. A write of zero starts nothing.
- R2: A completing command lowers the semaphore by one only when its flag bit 1 is set. Otherwise the semaphore is left unchanged.
- R3: After a command with flag bit 0 set, the next descriptor is taken from word 0 of the current descriptor. After a command with bit 0 clear, the channel halts, and only a new non-zero semaphore write restarts it.
- R4: The channel stops when the semaphore reaches zero. The pointer register then reads the link of the last completed command, and a later semaphore write resumes the chain from that point.
- R5: A semaphore write adds its value to the current count, including while the channel runs, so the run is extended.
- R6: Reading the semaphore returns the count of commands not yet finished. It saturates at its all-ones maximum, and it never rises except through a write.
- R7: Word 0 is read at the descriptor address and word 1 at address + 4, each with one cycle of read latency. Execute lasts max(1, count) cycles, and the decrement lands 4 + max(1, count) clock edges after the semaphore write edge of an idle channel.
- R8: Control bits are gate (bit 0), interrupt enable (bit 1), completion status (bit 2), reset (bit 3, reads 0) and busy (bit 4, read-only). Writing a one through the set or clear alias changes only that bit.
- R9: While the gate bit is set the channel is idle. Setting it aborts the current command without a decrement and leaves the semaphore unchanged. Clearing it resumes from the pointer register.
- R10: Completion of a command with flag bit 2 set raises the status bit. The interrupt output is high only while both status and enable are set, and a clear-alias write drops the status.
- R11: Writing reset bit 3 through the set alias idles the channel and zeroes the semaphore. The bit reads back as 0.
- R12: After the synchronous reset the control register reads 0x1 (gated), and the semaphore, pointer and interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_rd_en | output | 1 | Descriptor memory read request |
| mem_addr | output | ADDR_W | Descriptor memory byte address |
| mem_rdata | input | 32 | Descriptor read data, valid the cycle after the request |
| irq | output | 1 | Completion interrupt |

## Verification
Six descriptor chains are walked from a table, one after another. The chains mix chain-terminated and count-terminated runs, a command without the decrement flag, a semaphore larger than the chain so that a remainder is left, and a two-descriptor loop that only the count can stop. Together they separate halting on the chain flag from halting on a zero count. Directed runs then cover the following: the exact edge of the first decrement; resuming after the count runs out; extending a live run; a gate abort followed by a resume; saturation and zero writes while gated; the reset bit; and the masking of the interrupt by its enable.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    localparam logic [2:0] REG_NEXT = 3'd0;
    localparam logic [2:0] REG_SEMA = 3'd1;
    localparam logic [2:0] REG_CTRL = 3'd2;
    localparam logic [2:0] REG_SET  = 3'd3;
    localparam logic [2:0] REG_CLR  = 3'd4;

    localparam int CTL_GATE   = 0;
    localparam int CTL_IRQ_EN = 1;
    localparam int CTL_IRQ_ST = 2;
    localparam int CTL_RESET  = 3;
    localparam int CTL_BUSY   = 4;

    localparam int CMD_CHAIN = 0;
    localparam int CMD_DEC   = 1;
    localparam int CMD_IRQ   = 2;
    localparam int CYC_LSB   = 16;
    localparam int CYC_W     = 16;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_FETCH_LINK,
        SEQ_FETCH_CMD,
        SEQ_EXEC,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic irq;
        logic dec;
        logic chain;
    } cmd_flags_t;

    typedef struct packed {
        logic gate;
        logic irq_en;
        logic irq_st;
    } ctl_bits_t;

    function automatic cmd_flags_t cmd_decode(logic [31:0] w);
        cmd_flags_t f;
        f.chain = w[CMD_CHAIN];
        f.dec   = w[CMD_DEC];
        f.irq   = w[CMD_IRQ];
        return f;
    endfunction

    function automatic ctl_bits_t ctl_apply(ctl_bits_t cur, logic set_wr,
                                            logic clr_wr, logic [31:0] d);
        ctl_bits_t n = cur;
        if (set_wr) begin
            n.gate   = n.gate   | d[CTL_GATE];
            n.irq_en = n.irq_en | d[CTL_IRQ_EN];
            n.irq_st = n.irq_st | d[CTL_IRQ_ST];
        end
        if (clr_wr) begin
            n.gate   = n.gate   & ~d[CTL_GATE];
            n.irq_en = n.irq_en & ~d[CTL_IRQ_EN];
            n.irq_st = n.irq_st & ~d[CTL_IRQ_ST];
        end
        return n;
    endfunction

    function automatic logic [31:0] ctl_read(ctl_bits_t c, logic busy);
        logic [31:0] r = '0;
        r[CTL_GATE]   = c.gate;
        r[CTL_IRQ_EN] = c.irq_en;
        r[CTL_IRQ_ST] = c.irq_st;
        r[CTL_BUSY]   = busy;
        return r;
    endfunction

endpackage

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
    import dmaseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        irq_raise,
    output ctl_bits_t   ctl_q,
    output logic        gate_next,
    output logic        chan_reset,
    output logic        irq
);
    logic      set_wr;
    logic      clr_wr;
    ctl_bits_t ctl_d;

    assign set_wr = wr_en && (wr_addr == REG_SET);
    assign clr_wr = wr_en && (wr_addr == REG_CLR);

    always_comb begin
        ctl_d = ctl_apply(ctl_q, set_wr, clr_wr, wr_data);
        if (irq_raise) ctl_d.irq_st = 1'b1;
    end

    assign gate_next  = ctl_d.gate;
    assign chan_reset = set_wr && wr_data[CTL_RESET];
    assign irq        = ctl_q.irq_en & ctl_q.irq_st;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{gate: 1'b1, irq_en: 1'b0, irq_st: 1'b0};
        else     ctl_q <= ctl_d;
    end
endmodule

// File: rtl/dmaseq_sema.sv
module dmaseq_sema #(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [31:0]       add_val,
    input  logic              dec,
    output logic [SEMA_W-1:0] count
);
    localparam int          SUM_W = 34;
    localparam logic [SUM_W-1:0] MAXV = {{(SUM_W-SEMA_W){1'b0}}, {SEMA_W{1'b1}}};

    logic             dec_ok;
    logic [SUM_W-1:0] sum;

    assign dec_ok = dec && (count != '0);

    always_comb begin
        sum = SUM_W'(count) + (add_en ? SUM_W'(add_val) : '0) - SUM_W'(dec_ok);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)    count <= '0;
        else if (sum > MAXV) count <= {SEMA_W{1'b1}};
        else               count <= sum[SEMA_W-1:0];
    end
endmodule

// File: rtl/dmaseq_walker.sv
module dmaseq_walker
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              chan_reset,
    input  logic              arm,
    input  logic [SEMA_W-1:0] sema_cnt,
    input  logic              next_wr,
    input  logic [31:0]       next_wdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              dec_pulse,
    output logic              irq_raise,
    output logic              busy,
    output logic [ADDR_W-1:0] next_ptr,
    output seq_state_e        state
);
    localparam logic [ADDR_W-1:0] WORD1_OFS = ADDR_W'(4);

    logic [ADDR_W-1:0] link_q;
    cmd_flags_t        cmd_q;
    logic [CYC_W-1:0]  cnt_q;
    logic [CYC_W-1:0]  cyc_now;
    logic              first_q;
    logic              armed_q;
    logic              more;

    assign cyc_now   = mem_rdata[CYC_LSB +: CYC_W];
    assign mem_rd_en = (state == SEQ_FETCH_LINK) || (state == SEQ_FETCH_CMD);
    assign mem_addr  = (state == SEQ_FETCH_CMD) ? next_ptr + WORD1_OFS : next_ptr;
    assign busy      = (state != SEQ_IDLE);
    assign dec_pulse = (state == SEQ_DONE) && cmd_q.dec && !abort;
    assign irq_raise = (state == SEQ_DONE) && cmd_q.irq && !abort;
    assign more      = (sema_cnt != '0) &&
                       !(cmd_q.dec && (sema_cnt == SEMA_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            next_ptr <= '0;
            link_q   <= '0;
            cmd_q    <= '0;
            cnt_q    <= '0;
            first_q  <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            if (next_wr) next_ptr <= next_wdata[ADDR_W-1:0];
            if (abort) begin
                state <= SEQ_IDLE;
            end else begin
                unique case (state)
                    SEQ_IDLE: begin
                        if (armed_q && (sema_cnt != '0)) state <= SEQ_FETCH_LINK;
                    end
                    SEQ_FETCH_LINK: state <= SEQ_FETCH_CMD;
                    SEQ_FETCH_CMD: begin
                        link_q  <= mem_rdata[ADDR_W-1:0];
                        first_q <= 1'b1;
                        state   <= SEQ_EXEC;
                    end
                    SEQ_EXEC: begin
                        if (first_q) begin
                            first_q <= 1'b0;
                            cmd_q   <= cmd_decode(mem_rdata);
                            if (cyc_now <= CYC_W'(1)) state <= SEQ_DONE;
                            else                      cnt_q <= cyc_now - CYC_W'(2);
                        end else if (cnt_q == '0) begin
                            state <= SEQ_DONE;
                        end else begin
                            cnt_q <= cnt_q - CYC_W'(1);
                        end
                    end
                    SEQ_DONE: begin
                        next_ptr <= link_q;
                        if (!cmd_q.chain) begin
                            armed_q <= 1'b0;
                            state   <= SEQ_IDLE;
                        end else if (more) begin
                            state <= SEQ_FETCH_LINK;
                        end else begin
                            state <= SEQ_IDLE;
                        end
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
            if (arm)        armed_q <= 1'b1;
            if (chan_reset) armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_sem_seq.sv
module dma_sem_seq
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);
    ctl_bits_t         ctl_q;
    logic              gate_next;
    logic              chan_reset;
    logic              abort;
    logic              sema_wr;
    logic              arm;
    logic              next_wr;
    logic              dec_pulse;
    logic              irq_raise;
    logic              busy;
    logic [SEMA_W-1:0] sema_cnt;
    logic [ADDR_W-1:0] next_ptr;
    seq_state_e        seq_state;

    assign sema_wr = reg_wr_en && (reg_addr == REG_SEMA);
    assign arm     = sema_wr && (reg_wdata != '0);
    assign next_wr = reg_wr_en && (reg_addr == REG_NEXT);
    assign abort   = gate_next | chan_reset;

    dmaseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .irq_raise  (irq_raise),
        .ctl_q      (ctl_q),
        .gate_next  (gate_next),
        .chan_reset (chan_reset),
        .irq        (irq)
    );

    dmaseq_sema #(.SEMA_W(SEMA_W)) u_sema (
        .clk     (clk),
        .rst     (rst),
        .clr     (chan_reset),
        .add_en  (sema_wr),
        .add_val (reg_wdata),
        .dec     (dec_pulse),
        .count   (sema_cnt)
    );

    dmaseq_walker #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort),
        .chan_reset (chan_reset),
        .arm        (arm),
        .sema_cnt   (sema_cnt),
        .next_wr    (next_wr),
        .next_wdata (reg_wdata),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .dec_pulse  (dec_pulse),
        .irq_raise  (irq_raise),
        .busy       (busy),
        .next_ptr   (next_ptr),
        .state      (seq_state)
    );

    always_comb begin
        unique case (reg_addr)
            REG_NEXT: reg_rdata = 32'(next_ptr);
            REG_SEMA: reg_rdata = 32'(sema_cnt);
            REG_CTRL, REG_SET, REG_CLR: reg_rdata = ctl_read(ctl_q, busy);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_sem_seq_chk.sv
module dma_sem_seq_chk
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEMA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sema_wr,
    input logic [SEMA_W-1:0] sema,
    input seq_state_e        state,
    input logic              gate,
    input logic              irq_st,
    input logic              chan_reset,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr
);
    // R6: the count only rises through a write
    a_r6_no_rise: assert property (@(posedge clk) disable iff (rst)
        !$past(sema_wr) |-> (sema <= $past(sema)));

    // R2: a drop in the count comes only from a completing command
    a_r2_dec_in_done: assert property (@(posedge clk) disable iff (rst)
        (!$past(chan_reset) && (sema < $past(sema))) |-> $past(state == SEQ_DONE));

    // R9: a gated channel sits idle
    a_r9_gate_idle: assert property (@(posedge clk) disable iff (rst)
        gate |-> (state == SEQ_IDLE));

    // R10: status rises only on completion
    a_r10_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_st) |-> $past(state == SEQ_DONE));

    // R7: second word follows the first at +4
    a_r7_word_order: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_FETCH_CMD) |-> (mem_rd_en && (mem_addr == $past(mem_addr) + ADDR_W'(4))));

    // R11: reset bit empties the channel
    a_r11_chan_reset: assert property (@(posedge clk) disable iff (rst)
        chan_reset |=> ((state == SEQ_IDLE) && (sema == '0)));
endmodule

bind dma_sem_seq dma_sem_seq_chk #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sema_wr    (sema_wr),
    .sema       (sema_cnt),
    .state      (seq_state),
    .gate       (ctl_q.gate),
    .irq_st     (ctl_q.irq_st),
    .chan_reset (chan_reset),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr)
);

// File: tb/dma_sem_seq_test.sv
`timescale 1ns/1ps
module dma_sem_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int fetches = 0;

    logic [31:0] mem [0:63];

    always #2.5 clk = ~clk;

    dma_sem_seq uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[7:2]];
            if (mem_addr[3:0] == 4'd0) fetches <= fetches + 1;
        end
    end

    typedef struct packed {
        logic [7:0] start;
        logic [7:0] sema;
        logic [7:0] n_cmd;
        logic [7:0] sema_end;
        logic [7:0] irq_st;
        logic [7:0] next_end;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd0, 8'd3, 8'd3, 8'd0, 8'd1, 8'd3},
        '{8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd1},
        '{8'd3, 8'd2, 8'd3, 8'd0, 8'd1, 8'd0},
        '{8'd6, 8'd5, 8'd5, 8'd0, 8'd0, 8'd7},
        '{8'd3, 8'd3, 8'd3, 8'd1, 8'd1, 8'd0},
        '{8'd2, 8'd4, 8'd1, 8'd3, 8'd1, 8'd3}
    };

    function automatic logic [31:0] w1(int cyc, bit chain, bit dec, bit irqf);
        return {cyc[15:0], 13'd0, irqf, dec, chain};
    endfunction

    task automatic put(int i, int nxt, int cyc, bit chain, bit dec, bit irqf);
        mem[4*i]   = 32'(16*nxt);
        mem[4*i+1] = w1(cyc, chain, dec, irqf);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prep();
        wr(3'd3, 32'h8);   // reset bit through set alias
        wr(3'd4, 32'h4);   // clear status
    endtask

    task automatic waitc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int f0;
        int k;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        put(0, 1, 2, 1, 1, 0);
        put(1, 2, 1, 1, 1, 0);
        put(2, 3, 0, 0, 1, 1);
        put(3, 4, 1, 1, 0, 0);
        put(4, 5, 3, 1, 1, 0);
        put(5, 0, 2, 0, 1, 1);
        put(6, 7, 1, 1, 1, 0);
        put(7, 6, 1, 1, 1, 0);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd(3'd2, d); chk("R12 ctrl", d, 32'h1);
        rd(3'd1, d); chk("R12 sema", d, 32'h0);
        rd(3'd0, d); chk("R12 next", d, 32'h0);
        chk("R12 irq", 32'(irq), 32'h0);

        // gated: counts accumulate and saturate, nothing is fetched
        f0 = fetches;
        wr(3'd1, 32'd200);
        wr(3'd1, 32'd100);
        waitc(20);
        rd(3'd1, d); chk("R6 saturate", d, 32'hFF);
        chk("R9 gated no fetch", 32'(fetches - f0), 32'h0);
        wr(3'd3, 32'h8);
        rd(3'd1, d); chk("R11 sema zero", d, 32'h0);
        rd(3'd2, d); chk("R11 bit reads 0, idle", d, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd2, d); chk("R8 clear alias gate", d, 32'h0);

        // zero write starts nothing
        wr(3'd0, 32'd0);
        f0 = fetches;
        wr(3'd1, 32'd0);
        waitc(20);
        chk("R1 zero write", 32'(fetches - f0), 32'h0);

        foreach (VECS[v]) begin
            prep();
            wr(3'd0, 32'(16 * VECS[v].start));
            f0 = fetches;
            wr(3'd1, 32'(VECS[v].sema));
            waitc(150);
            chk("R1 R3 command count", 32'(fetches - f0), 32'(VECS[v].n_cmd));
            rd(3'd1, d); chk("R2 R4 final sema", d, 32'(VECS[v].sema_end));
            rd(3'd2, d); chk("R10 status", 32'(d[2]), 32'(VECS[v].irq_st));
            rd(3'd0, d); chk("R3 R4 next pointer", d, 32'(16 * VECS[v].next_end));
        end

        // exact decrement edge
        prep();
        wr(3'd0, 32'd64);
        reg_addr = 3'd1;
        wr(3'd1, 32'd1);
        k = 0;
        do begin
            @(posedge clk); #1; k++;
        end while (reg_rdata == 32'd1 && k < 50);
        chk("R7 decrement edge", 32'(k), 32'd7);
        waitc(5);
        rd(3'd0, d); chk("R4 stop at zero keeps link", d, 32'd80);
        f0 = fetches;
        wr(3'd1, 32'd1);
        waitc(40);
        chk("R4 resume one command", 32'(fetches - f0), 32'd1);
        rd(3'd0, d); chk("R4 resume link", d, 32'd0);

        // extension while running
        prep();
        wr(3'd0, 32'd96);
        f0 = fetches;
        wr(3'd1, 32'd1);
        wr(3'd1, 32'd2);
        waitc(100);
        chk("R5 extended count", 32'(fetches - f0), 32'd3);
        rd(3'd1, d); chk("R5 sema", d, 32'd0);
        rd(3'd0, d); chk("R5 next", d, 32'd112);

        // gate abort and resume
        prep();
        wr(3'd0, 32'd96);
        wr(3'd1, 32'd5);
        waitc(10);
        wr(3'd3, 32'h1);
        rd(3'd2, d); chk("R9 busy drops", 32'(d[4]), 32'h0);
        rd(3'd1, d);
        k = int'(d);
        f0 = fetches;
        waitc(30);
        rd(3'd1, d); chk("R9 sema held", d, 32'(k));
        chk("R9 no fetch while gated", 32'(fetches - f0), 32'h0);
        wr(3'd4, 32'h1);
        waitc(100);
        rd(3'd1, d); chk("R9 resumed sema", d, 32'h0);
        rd(3'd0, d); chk("R9 no lost command", d, 32'd112);

        // interrupt masking
        prep();
        wr(3'd0, 32'd32);
        wr(3'd1, 32'd1);
        waitc(30);
        chk("R10 masked", 32'(irq), 32'h0);
        wr(3'd3, 32'h2);
        rd(3'd2, d); chk("R8 set alias", d, 32'h6);
        chk("R10 enabled", 32'(irq), 32'h1);
        wr(3'd4, 32'h4);
        rd(3'd2, d); chk("R10 cleared", d, 32'h2);
        chk("R10 line low", 32'(irq), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule